// File: doc/BRIEF.md
# Flash Command Register Front-End

This block is the software-facing half of a flash controller. It sits on a simple 32-bit register bus. Software stages a command there: an opcode with size, an options word, a target address, per-byte lane enables, several data words and a guard (protect) word. Writing 1 to the go bit then launches the command. The block freezes the staged registers for as long as the command runs. It screens out malformed or unsafe requests itself. It passes every other request to an external sequencer through a request/acknowledge port, and folds the sequencer's result into a status word.

When a command finishes, the lane enables return to zero and the data words return to all ones, so a stale payload cannot be reused by accident. A single done interrupt is kept in a raw latch. That latch can be forced or acknowledged by software, and it is gated by an enable bit to produce the interrupt output. The array, the pulse timing and the address translation are outside the block and reach it only through the sequencer port.

Top module: `fcmd_frontend`

## Requirements
- R1: After reset, status reads 0, go reads 0, the lane enables read 0, every data word and the guard word read FFFFFFFFh, opcode, options and target read 0, and irq_o and seq_req are low.
- R2: Register word addresses on reg_addr: 0 go (bit 0), 1 opcode (command in bits 2:0, size in bits 6:4), 2 options, 3 target, 4 lane enables (16 bits), 5 guard, 6 status (read-only), 7 raw interrupt, 8 interrupt enable (bit 0), 9 masked interrupt, 10 force (write-only), 11 acknowledge (write-only), 16 to 19 data words 0 to 3. While idle, staged registers read back what was written.
- R3: A write of 1 to go while idle makes go read 1 and status read exactly 4h (in-progress, bit 2) from the next cycle. This clears done, pass and every fail bit of the previous command.
- R4: While go reads 1, writes to go, opcode, options, target, lane enables, guard and data are ignored.
- R5: Command codes 3 and 7, any size code 6 or 7, and blank verify (code 6) with a size other than 0 complete one cycle after the start with status 1001h (done, bit 12 miscellaneous fail, pass clear). seq_req stays low.
- R6: Program (1) or erase (2) while any bank_busy bit is set, sampled one cycle after the start, completes with status 81h (done, bit 7 mode fail). seq_req stays low.
- R7: No-op (0) and clear-status (5) complete one cycle after the start with status 3h (done and pass). seq_req stays low.
- R8: Program, erase, mode change (4) and blank verify with size 0 raise seq_req from the cycle after the start until seq_done is seen. During that time the seq_* outputs carry the staged registers.
- R9: On seq_done, status becomes done (bit 0), with seq_fail[0], [1], [2] and [3] mapped to bits 4, 5, 6 and 8. Pass (bit 1) is set only when seq_fail is 0. Go returns to 0.
- R10: Completion of any command clears the lane enables to 0 and sets every data word to FFFFFFFFh.
- R11: The raw interrupt bit sets on completion or on a force write with bit 0 = 1. It clears on an acknowledge write with bit 0 = 1 whatever the enable. Writes of 0 to force or acknowledge change nothing. The masked read and irq_o equal raw AND enable.
- R12: Completion in the same cycle as an acknowledge write leaves the raw interrupt set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| bank_busy | input | NUM_BANKS | One bit per bank that is not in read mode |
| seq_req | output | 1 | Command handed to the sequencer |
| seq_cmd | output | 3 | Staged command code |
| seq_size | output | 3 | Staged size code |
| seq_opts | output | 32 | Staged options word |
| seq_addr | output | 32 | Staged target address |
| seq_lanes | output | LANE_W | Staged byte lane enables |
| seq_data | output | DATA_WORDS*32 | Staged data words, word 0 in the low bits |
| seq_guard | output | 32 | Staged guard word |
| seq_done | input | 1 | Sequencer finished; sampled while seq_req is high |
| seq_fail | input | 4 | Sequencer fail flags, valid with seq_done |
| irq_o | output | 1 | Done interrupt, raw AND enable |

## Verification
The bench targets four kinds of mistake: a launched command whose staged registers can still be overwritten, a status that keeps fail bits from the previous command, a rejected request that still reaches the sequencer, and an acknowledge that wins over a completion in the same cycle. A design that got these wrong would send a changed address to the sequencer, would report a failure for a command that passed, would start an operation while a bank is busy or while the code is malformed, or would lose the done interrupt. Illegal codes, blank verify with a nonzero size, and a fail word with two flags set are each driven so that every status bit position is exercised. A reference model checks each cycle's read data, interrupt and request against the outcome it expects.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned STAT_W = 13;

  // command codes
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_CLRST = 3'd5;
  localparam logic [2:0] OP_BLANK = 3'd6;
  localparam logic [2:0] SZ_LAST  = 3'd5;

  // status bit positions
  localparam int unsigned ST_DONE   = 0;
  localparam int unsigned ST_PASS   = 1;
  localparam int unsigned ST_BUSY   = 2;
  localparam int unsigned ST_PROT   = 4;
  localparam int unsigned ST_VERIFY = 5;
  localparam int unsigned ST_ADDR   = 6;
  localparam int unsigned ST_MODE   = 7;
  localparam int unsigned ST_DATA   = 8;
  localparam int unsigned ST_MISC   = 12;

  // register word indices
  localparam int unsigned RI_GO      = 0;
  localparam int unsigned RI_OPCODE  = 1;
  localparam int unsigned RI_OPTIONS = 2;
  localparam int unsigned RI_TARGET  = 3;
  localparam int unsigned RI_LANES   = 4;
  localparam int unsigned RI_GUARD   = 5;
  localparam int unsigned RI_STATUS  = 6;
  localparam int unsigned RI_IRQRAW  = 7;
  localparam int unsigned RI_IRQEN   = 8;
  localparam int unsigned RI_IRQMSK  = 9;
  localparam int unsigned RI_IRQSET  = 10;
  localparam int unsigned RI_IRQACK  = 11;
  localparam int unsigned RI_DATA0   = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CHECK = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [2:0]           cmd_i,
  input  logic [2:0]           size_i,
  input  logic [NUM_BANKS-1:0] bank_busy_i,
  output logic                 finish_now_o,
  output logic [STAT_W-1:0]    fail_o
);
  logic bad_code, writes_array, mode_bad, local_only;

  always_comb begin
    bad_code     = (cmd_i == 3'd3) || (cmd_i == 3'd7) || (size_i > SZ_LAST) ||
                   ((cmd_i == OP_BLANK) && (size_i != 3'd0));
    writes_array = (cmd_i == OP_PROG) || (cmd_i == OP_ERASE);
    mode_bad     = writes_array && (|bank_busy_i);
    local_only   = (cmd_i == OP_NOP) || (cmd_i == OP_CLRST);
    fail_o       = '0;
    if (bad_code)      fail_o[ST_MISC] = 1'b1;
    else if (mode_bad) fail_o[ST_MODE] = 1'b1;
    finish_now_o = bad_code || mode_bad || local_only;
  end
endmodule

// File: rtl/fcmd_seqctl.sv
module fcmd_seqctl
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              finish_now_i,
  input  logic [STAT_W-1:0] local_fail_i,
  input  logic              seq_done_i,
  input  logic [3:0]        seq_fail_i,
  output phase_e            phase_o,
  output logic              complete_o,
  output logic [STAT_W-1:0] status_o
);
  phase_e            phase_q, phase_d;
  logic [STAT_W-1:0] status_q, status_d;

  always_comb begin
    phase_d    = phase_q;
    status_d   = status_q;
    complete_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d            = PH_CHECK;
        status_d           = '0;
        status_d[ST_BUSY]  = 1'b1;
      end
      PH_CHECK: if (finish_now_i) begin
        complete_o         = 1'b1;
        phase_d            = PH_IDLE;
        status_d           = local_fail_i;
        status_d[ST_DONE]  = 1'b1;
        status_d[ST_PASS]  = ~|local_fail_i;
      end else begin
        phase_d            = PH_WAIT;
      end
      PH_WAIT: if (seq_done_i) begin
        complete_o          = 1'b1;
        phase_d             = PH_IDLE;
        status_d            = '0;
        status_d[ST_DONE]   = 1'b1;
        status_d[ST_PASS]   = ~|seq_fail_i;
        status_d[ST_PROT]   = seq_fail_i[0];
        status_d[ST_VERIFY] = seq_fail_i[1];
        status_d[ST_ADDR]   = seq_fail_i[2];
        status_d[ST_DATA]   = seq_fail_i[3];
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      status_q <= '0;
    end else begin
      phase_q  <= phase_d;
      status_q <= status_d;
    end
  end

  assign phase_o  = phase_q;
  assign status_o = status_q;
endmodule

// File: rtl/fcmd_irq.sv
module fcmd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic complete_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  output logic raw_o,
  output logic en_o,
  output logic irq_o
);
  logic raw_q, raw_d, en_q, en_d;

  always_comb begin
    raw_d = raw_q;
    if (complete_i || set_i) raw_d = 1'b1;
    else if (clr_i)          raw_d = 1'b0;
    en_d = en_we_i ? en_wd_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = raw_q & en_q;
endmodule

// File: rtl/fcmd_frontend.sv
module fcmd_frontend
  import fcmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_WORDS = 4,
  parameter int unsigned LANE_W     = 16,
  parameter int unsigned NUM_BANKS  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [WORD_W-1:0]            reg_wdata,
  output logic [WORD_W-1:0]            reg_rdata,
  input  logic [NUM_BANKS-1:0]         bank_busy,
  output logic                         seq_req,
  output logic [2:0]                   seq_cmd,
  output logic [2:0]                   seq_size,
  output logic [WORD_W-1:0]            seq_opts,
  output logic [WORD_W-1:0]            seq_addr,
  output logic [LANE_W-1:0]            seq_lanes,
  output logic [DATA_WORDS*WORD_W-1:0] seq_data,
  output logic [WORD_W-1:0]            seq_guard,
  input  logic                         seq_done,
  input  logic [3:0]                   seq_fail,
  output logic                         irq_o
);
  localparam int unsigned DATA_W = DATA_WORDS * WORD_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned idx);
    return a == ADDR_W'(idx);
  endfunction

  phase_e            phase;
  logic              busy, complete, finish_now, start, cfg_open;
  logic [STAT_W-1:0] local_fail, status;
  logic              irq_raw, irq_en, irq_set, irq_clr, irq_en_we;

  assign busy     = (phase != PH_IDLE);
  assign cfg_open = reg_we && !busy;
  assign start    = cfg_open && hit(reg_addr, RI_GO) && reg_wdata[0];

  // staged registers
  logic [2:0]        cmd_q, cmd_d, size_q, size_d;
  logic [WORD_W-1:0] opts_q, opts_d, tgt_q, tgt_d, guard_q, guard_d;
  logic [LANE_W-1:0] lanes_q, lanes_d;
  logic [WORD_W-1:0] data_q [DATA_WORDS];

  always_comb begin
    cmd_d   = cmd_q;
    size_d  = size_q;
    opts_d  = opts_q;
    tgt_d   = tgt_q;
    guard_d = guard_q;
    lanes_d = lanes_q;
    if (cfg_open && hit(reg_addr, RI_OPCODE)) begin
      cmd_d  = reg_wdata[2:0];
      size_d = reg_wdata[6:4];
    end
    if (cfg_open && hit(reg_addr, RI_OPTIONS)) opts_d  = reg_wdata;
    if (cfg_open && hit(reg_addr, RI_TARGET))  tgt_d   = reg_wdata;
    if (cfg_open && hit(reg_addr, RI_GUARD))   guard_d = reg_wdata;
    if (complete)                                   lanes_d = '0;
    else if (cfg_open && hit(reg_addr, RI_LANES))   lanes_d = reg_wdata[LANE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q   <= '0;
      size_q  <= '0;
      opts_q  <= '0;
      tgt_q   <= '0;
      guard_q <= '1;
      lanes_q <= '0;
    end else begin
      cmd_q   <= cmd_d;
      size_q  <= size_d;
      opts_q  <= opts_d;
      tgt_q   <= tgt_d;
      guard_q <= guard_d;
      lanes_q <= lanes_d;
    end
  end

  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_data
    logic              wr_en;
    logic [WORD_W-1:0] word_d;
    assign wr_en = cfg_open && hit(reg_addr, RI_DATA0 + w);
    always_comb begin
      word_d = data_q[w];
      if (complete)   word_d = '1;
      else if (wr_en) word_d = reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) data_q[w] <= '1;
      else            data_q[w] <= word_d;
    end
    assign seq_data[w*WORD_W +: WORD_W] = data_q[w];
  end

  fcmd_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .cmd_i        (cmd_q),
    .size_i       (size_q),
    .bank_busy_i  (bank_busy),
    .finish_now_o (finish_now),
    .fail_o       (local_fail)
  );

  fcmd_seqctl u_seqctl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start),
    .finish_now_i (finish_now),
    .local_fail_i (local_fail),
    .seq_done_i   (seq_done),
    .seq_fail_i   (seq_fail),
    .phase_o      (phase),
    .complete_o   (complete),
    .status_o     (status)
  );

  assign irq_set   = reg_we && hit(reg_addr, RI_IRQSET) && reg_wdata[0];
  assign irq_clr   = reg_we && hit(reg_addr, RI_IRQACK) && reg_wdata[0];
  assign irq_en_we = reg_we && hit(reg_addr, RI_IRQEN);

  fcmd_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .complete_i (complete),
    .set_i      (irq_set),
    .clr_i      (irq_clr),
    .en_we_i    (irq_en_we),
    .en_wd_i    (reg_wdata[0]),
    .raw_o      (irq_raw),
    .en_o       (irq_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, RI_GO))      reg_rdata[0] = busy;
    if (hit(reg_addr, RI_OPCODE)) begin
      reg_rdata[2:0] = cmd_q;
      reg_rdata[6:4] = size_q;
    end
    if (hit(reg_addr, RI_OPTIONS)) reg_rdata = opts_q;
    if (hit(reg_addr, RI_TARGET))  reg_rdata = tgt_q;
    if (hit(reg_addr, RI_LANES))   reg_rdata[LANE_W-1:0] = lanes_q;
    if (hit(reg_addr, RI_GUARD))   reg_rdata = guard_q;
    if (hit(reg_addr, RI_STATUS))  reg_rdata[STAT_W-1:0] = status;
    if (hit(reg_addr, RI_IRQRAW))  reg_rdata[0] = irq_raw;
    if (hit(reg_addr, RI_IRQEN))   reg_rdata[0] = irq_en;
    if (hit(reg_addr, RI_IRQMSK))  reg_rdata[0] = irq_o;
    for (int w = 0; w < DATA_WORDS; w++)
      if (hit(reg_addr, RI_DATA0 + int'(w))) reg_rdata = data_q[w];
  end

  assign seq_req   = (phase == PH_WAIT);
  assign seq_cmd   = cmd_q;
  assign seq_size  = size_q;
  assign seq_opts  = opts_q;
  assign seq_addr  = tgt_q;
  assign seq_lanes = lanes_q;
  assign seq_guard = guard_q;
endmodule

// File: rtl/fcmd_frontend_chk.sv
module fcmd_frontend_chk
  import fcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit0,
  input logic              busy,
  input phase_e            phase,
  input logic              misc_flag,
  input logic              complete,
  input logic [STAT_W-1:0] status,
  input logic              seq_req,
  input logic [WORD_W-1:0] seq_addr,
  input logic [LANE_W-1:0] seq_lanes,
  input logic [DATA_W-1:0] seq_data,
  input logic              irq_raw
);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RI_GO) && wbit0 && !busy) |=> (busy && status == STAT_W'(4)));

  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RI_TARGET) && busy) |=> $stable(seq_addr));

  p_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHECK && misc_flag) |=> (status[ST_DONE] && status[ST_MISC] && !status[ST_PASS] && !seq_req));

  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> (busy && status[ST_BUSY]));

  p_pass_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_PASS] |-> (status[ST_DONE] && !status[ST_BUSY]));

  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (seq_lanes == '0 && seq_data == '1));

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> irq_raw);
endmodule

bind fcmd_frontend fcmd_frontend_chk #(
  .ADDR_W (ADDR_W),
  .LANE_W (LANE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .wbit0     (reg_wdata[0]),
  .busy      (busy),
  .phase     (phase),
  .misc_flag (local_fail[12]),
  .complete  (complete),
  .status    (status),
  .seq_req   (seq_req),
  .seq_addr  (seq_addr),
  .seq_lanes (seq_lanes),
  .seq_data  (seq_data),
  .irq_raw   (irq_raw)
);

// File: tb/fcmd_frontend_tb.sv
module fcmd_frontend_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, reg_we, seq_req, seq_done, irq_o;
  logic [4:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata, seq_opts, seq_addr, seq_guard;
  logic [1:0]   bank_busy;
  logic [2:0]   seq_cmd, seq_size;
  logic [15:0]  seq_lanes;
  logic [127:0] seq_data;
  logic [3:0]   seq_fail;

  fcmd_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_busy(bank_busy),
    .seq_req(seq_req), .seq_cmd(seq_cmd), .seq_size(seq_size),
    .seq_opts(seq_opts), .seq_addr(seq_addr), .seq_lanes(seq_lanes),
    .seq_data(seq_data), .seq_guard(seq_guard), .seq_done(seq_done),
    .seq_fail(seq_fail), .irq_o(irq_o)
  );

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- sequencer stub ----------------
  int       stub_lat = 2;
  logic [3:0] stub_fail = 4'h0;
  int       req_age = 0;
  bit       req_seen = 0;

  always @(negedge clk) begin
    seq_done = 1'b0;
    seq_fail = stub_fail;
    if (seq_req === 1'b1) begin
      if (req_age >= stub_lat) seq_done = 1'b1;
      req_age++;
    end else begin
      req_age = 0;
    end
  end
  always @(posedge clk) begin
    #1;
    if (seq_req === 1'b1) req_seen = 1;
  end

  // ---------------- reference model ----------------
  int        m_rcnt = 0;
  int        m_phase;             // 0 idle, 1 screening, 2 with sequencer
  bit [2:0]  m_cmd, m_size;
  bit [31:0] m_opts, m_tgt, m_guard, m_st;
  bit [15:0] m_lanes;
  bit [31:0] m_data [4];
  bit        m_raw, m_en;

  task automatic m_reset();
    m_phase = 0; m_cmd = 0; m_size = 0; m_opts = 0; m_tgt = 0;
    m_guard = '1; m_st = 0; m_lanes = 0; m_raw = 0; m_en = 0;
    foreach (m_data[i]) m_data[i] = '1;
  endtask

  always @(posedge clk) begin : model
    bit        comp, idle0, bad, modeb;
    bit [31:0] a;
    comp = 0;
    if (!rst_n) begin
      m_rcnt = 0; m_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++; m_reset();
    end else begin
      idle0 = (m_phase == 0);
      a = 32'(reg_addr);
      if (m_phase == 1) begin
        bad   = (m_cmd == 3) || (m_cmd == 7) || (m_size > 5) || (m_cmd == 6 && m_size != 0);
        modeb = (m_cmd == 1 || m_cmd == 2) && (bank_busy != 0);
        if (bad)                        begin comp = 1; m_st = 32'h1001; end
        else if (modeb)                 begin comp = 1; m_st = 32'h81;   end
        else if (m_cmd == 0 || m_cmd == 5) begin comp = 1; m_st = 32'h3; end
        else m_phase = 2;
      end else if (m_phase == 2 && seq_done) begin
        comp = 1;
        m_st = 32'h1 | (seq_fail == 0 ? 32'h2 : 32'h0) |
               (32'(seq_fail[0]) << 4) | (32'(seq_fail[1]) << 5) |
               (32'(seq_fail[2]) << 6) | (32'(seq_fail[3]) << 8);
      end
      if (reg_we && idle0) begin
        case (a)
          0: if (reg_wdata[0]) begin m_phase = 1; m_st = 32'h4; end
          1: begin m_cmd = reg_wdata[2:0]; m_size = reg_wdata[6:4]; end
          2: m_opts = reg_wdata;
          3: m_tgt = reg_wdata;
          4: m_lanes = reg_wdata[15:0];
          5: m_guard = reg_wdata;
          16, 17, 18, 19: m_data[a-16] = reg_wdata;
          default: ;
        endcase
      end
      if (comp) begin
        m_phase = 0; m_lanes = 0;
        foreach (m_data[i]) m_data[i] = '1;
      end
      if (reg_we && a == 8) m_en = reg_wdata[0];
      if (comp || (reg_we && a == 10 && reg_wdata[0])) m_raw = 1;
      else if (reg_we && a == 11 && reg_wdata[0])      m_raw = 0;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd0:  return {31'b0, m_phase != 0};
      5'd1:  return {25'b0, m_size, 1'b0, m_cmd};
      5'd2:  return m_opts;
      5'd3:  return m_tgt;
      5'd4:  return {16'b0, m_lanes};
      5'd5:  return m_guard;
      5'd6:  return m_st;
      5'd7:  return {31'b0, m_raw};
      5'd8:  return {31'b0, m_en};
      5'd9:  return {31'b0, m_raw & m_en};
      5'd16, 5'd17, 5'd18, 5'd19: return m_data[a - 5'd16];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    #3;
    if (!finished) begin
      chk({cur_req, " model rdata"}, reg_rdata, exp_rd(reg_addr));
      chk({cur_req, " model irq"}, {31'b0, irq_o}, {31'b0, m_raw & m_en});
      chk({cur_req, " model req"}, {31'b0, seq_req}, {31'b0, m_phase == 2});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a[4:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    reg_addr = a[4:0];
    #1;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    reg_addr = 5'd0;
    while (k < 60) begin
      #1;
      if (reg_rdata[0] === 1'b0) break;
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    chk({tag, " go cleared"}, k < 60, 1);
  endtask

  task automatic run_cmd(input logic [31:0] opcode, input string tag);
    wr(1, opcode);
    req_seen = 0;
    wr(0, 1);
    wait_idle(tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog: actual=timeout expected=finish", cur_req);
      finish_run();
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 5'd0; reg_wdata = 32'h0;
    bank_busy = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    rd(6, 32'h0, "R1 status");
    rd(0, 32'h0, "R1 go");
    rd(4, 32'h0, "R1 lanes");
    rd(17, 32'hFFFF_FFFF, "R1 data1");
    rd(5, 32'hFFFF_FFFF, "R1 guard");
    rd(1, 32'h0, "R1 opcode");
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 req", {31'b0, seq_req}, 32'h0);

    cur_req = "R2";
    wr(1, 32'hFFFF_FF31);
    wr(2, 32'h1234_5678);
    wr(3, 32'h0000_0A40);
    wr(4, 32'h0000_FFFF);
    wr(5, 32'h0000_0000);
    for (int i = 0; i < 4; i++) wr(16 + i, 32'hA5A5_0000 + i);
    rd(1, 32'h31, "R2 opcode fields");
    rd(2, 32'h1234_5678, "R2 options");
    rd(3, 32'h0000_0A40, "R2 target");
    rd(19, 32'hA5A5_0003, "R2 data3");
    wr(8, 1);

    cur_req = "R3";
    stub_lat = 6; stub_fail = 4'h0;
    req_seen = 0;
    wr(0, 1);
    rd(6, 32'h4, "R3 in progress");

    cur_req = "R4";
    wr(3, 32'hDEAD_0000);
    wr(16, 32'h0);
    wr(4, 32'h1);
    rd(3, 32'h0000_0A40, "R4 target locked");

    cur_req = "R8";
    chk("R8 req high", {31'b0, seq_req}, 32'h1);
    chk("R8 cmd", {29'b0, seq_cmd}, 32'h1);
    chk("R8 size", {29'b0, seq_size}, 32'h3);
    chk("R8 addr", seq_addr, 32'h0000_0A40);
    chk("R8 opts", seq_opts, 32'h1234_5678);
    chk("R8 lanes", {16'b0, seq_lanes}, 32'h0000_FFFF);
    chk("R8 guard", seq_guard, 32'h0);
    chk("R8 data0", seq_data[31:0], 32'hA5A5_0000);
    chk("R8 data2", seq_data[95:64], 32'hA5A5_0002);
    wait_idle("R8");

    cur_req = "R9";
    rd(6, 32'h3, "R9 pass status");
    cur_req = "R10";
    rd(4, 32'h0, "R10 lanes cleared");
    rd(16, 32'hFFFF_FFFF, "R10 data0 restored");
    rd(18, 32'hFFFF_FFFF, "R10 data2 restored");

    cur_req = "R11";
    chk("R11 irq after done", {31'b0, irq_o}, 32'h1);
    wr(11, 0);
    chk("R11 ack zero no effect", {31'b0, irq_o}, 32'h1);
    wr(11, 1);
    chk("R11 ack clears", {31'b0, irq_o}, 32'h0);
    wr(8, 0);
    wr(10, 0);
    rd(7, 32'h0, "R11 force zero no effect");
    wr(10, 1);
    rd(7, 32'h1, "R11 force sets raw");
    rd(9, 32'h0, "R11 masked off");
    chk("R11 irq masked", {31'b0, irq_o}, 32'h0);
    wr(11, 1);
    rd(7, 32'h0, "R11 ack while disabled");
    wr(8, 1);

    cur_req = "R9";
    stub_lat = 1; stub_fail = 4'b1010;
    run_cmd(32'h42, "R9");
    rd(6, 32'h121, "R9 fail mapping");
    stub_fail = 4'b0101;
    wr(1, 32'h04);
    wr(0, 1);
    rd(6, 32'h4, "R3 old fails cleared");
    wait_idle("R9");
    rd(6, 32'h51, "R9 fail mapping low bits");
    stub_fail = 4'h0;

    cur_req = "R6";
    bank_busy = 2'b10;
    run_cmd(32'h01, "R6");
    rd(6, 32'h81, "R6 mode fail");
    chk("R6 no request", req_seen, 0);
    run_cmd(32'h02, "R6");
    rd(6, 32'h81, "R6 erase mode fail");
    bank_busy = 2'b00;

    cur_req = "R5";
    run_cmd(32'h03, "R5");
    rd(6, 32'h1001, "R5 code 3");
    chk("R5 no request", req_seen, 0);
    run_cmd(32'h16, "R5");
    rd(6, 32'h1001, "R5 blank verify size 1");
    run_cmd(32'h60, "R5");
    rd(6, 32'h1001, "R5 size 6");
    run_cmd(32'h07, "R5");
    rd(6, 32'h1001, "R5 code 7");

    cur_req = "R8";
    run_cmd(32'h06, "R8");
    rd(6, 32'h3, "R8 blank verify size 0");
    chk("R8 request seen", req_seen, 1);

    cur_req = "R7";
    run_cmd(32'h00, "R7");
    rd(6, 32'h3, "R7 no-op pass");
    chk("R7 no request", req_seen, 0);
    run_cmd(32'h05, "R7");
    rd(6, 32'h3, "R7 clear status pass");

    cur_req = "R12";
    wr(11, 1);
    rd(7, 32'h0, "R12 raw cleared first");
    wr(1, 32'h00);
    wr(0, 1);
    wr(11, 1);
    rd(7, 32'h1, "R12 completion beats ack");
    chk("R12 irq", {31'b0, irq_o}, 32'h1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule